// File: doc/BRIEF.md
# Hardware Lock Bank with Read-to-Acquire

This block holds a bank of single-bit mutual-exclusion locks that several processors share over one simple register bus. Software tries to take a lock by reading that lock's 32-bit register. The read that finds the lock free returns 0, and the same access marks the lock as held, so the reader now owns it. A read that finds the lock already held returns 1 and changes nothing. The owner gives the lock back by writing zero to the register. The bus carries one access per cycle, and that access order is the only arbitration between contending masters.

A status register reports how many locks the bank has, as a one-hot multiple of 32 in a four-bit field. It also has a ready flag that reads 1 once reset is over. The bank size is set at build time to 32, 64, 128 or 256 locks. Lock registers are consecutive words starting at byte offset 0x800. The status register sits at byte offset 0x014.

Top module: `hw_lock_bank`

## Requirements
- R1: While rst_n is low, and in the cycle after it, rdata is 0. After reset every lock reads as free (value 0).
- R2: A read of byte offset 0x014 returns the status word on the next cycle. Bit 0 is 1 (ready). Bits 27:24 hold NUM_LOCKS/32, which is 1, 2, 4 or 8. All other bits are 0.
- R3: A read of a free lock returns 0 on the next cycle, and the lock is held from the same clock edge on.
- R4: A read of a held lock returns 1 on the next cycle and leaves the lock held.
- R5: A write of 0 to a lock register releases that lock, so the next read of it returns 0.
- R6: A write of any nonzero value to a lock register is ignored.
- R7: Writes to the status register are ignored, and a later status read returns the same word.
- R8: These accesses return 0 and change no lock: reads of unmapped offsets, reads of lock offsets at or beyond 0x800 + 4*NUM_LOCKS, and reads of lock offsets that are not word aligned. Writes to the same offsets also change no lock.
- R9: When rd_en and wr_en are high in the same cycle, only the read is performed and the write is dropped.
- R10: In the cycle after a cycle with rd_en low, rdata is 0.
- R11: Lock i lives at byte offset 0x800 + 4*i. An access changes only the lock it addresses, and at most one lock is acquired per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W (12) | Byte address of the access |
| rd_en | input | 1 | Read request (acquire attempt on a lock register) |
| wr_en | input | 1 | Write request |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |

## Verification
The bench first reads every lock once after reset, which should find all of them free, and then reads them all again, which should find all of them held. This separates a working test-and-set from a read with no side effect. Releases and nonzero writes go to scattered single locks, with reads of the neighbouring locks around them, to show that only the addressed lock moves. Reads and writes to unmapped, out-of-range and misaligned offsets, along with cycles where a read and a write collide, check the decode edges and the read-wins rule. Idle and write-only cycles check that rdata returns to zero.

// File: rtl/hwlock_pkg.sv
// Package: shared constants and types for the hardware lock bank.
// Assumes byte addressing, with 32-bit registers on word boundaries.
package hwlock_pkg;

    localparam int DATA_W        = 32;
    localparam int STATUS_OFFSET = 'h014;
    localparam int LOCK_BASE     = 'h800;
    localparam int LOCK_STRIDE   = 4;
    localparam int COUNT_LSB     = 24;
    localparam int COUNT_W       = 4;
    localparam int LOCKS_PER_UNIT = 32;

    localparam logic LOCK_FREE = 1'b0;
    localparam logic LOCK_HELD = 1'b1;

    // Target of a bus access after decode.
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_LOCK   = 2'd2
    } sel_e;

endpackage

// File: rtl/hwlock_decode.sv
// Module: address decoder for the lock bank.
// Sorts a byte address into status, lock or unmapped. For lock hits it
// also gives the lock index. Offsets past the implemented lock count and
// offsets that are not word aligned decode as unmapped.
module hwlock_decode
    import hwlock_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_LOCKS = 32,
    parameter int IDX_W     = $clog2(NUM_LOCKS)
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [IDX_W-1:0]  idx
);

    localparam int LOCK_SPAN = LOCK_STRIDE * NUM_LOCKS;

    logic [ADDR_W-1:0] ofs;
    logic              in_window;
    logic              aligned;

    // Offset of the address from the first lock register, with a window check.
    always_comb begin
        ofs       = addr - ADDR_W'(LOCK_BASE);
        in_window = (32'(addr) >= LOCK_BASE) && (32'(ofs) < LOCK_SPAN);
        aligned   = (ofs[1:0] == 2'b00);
        idx       = ofs[IDX_W+1:2];
    end

    // Choose the access target.
    always_comb begin
        if (32'(addr) == STATUS_OFFSET)
            sel = SEL_STATUS;
        else if (in_window && aligned)
            sel = SEL_LOCK;
        else
            sel = SEL_NONE;
    end

endmodule

// File: rtl/hwlock_array.sv
// Module: storage for the lock states, one flop per lock.
// A set request marks one lock held and a clear request frees one lock.
// The top never raises both for the same cycle, but set is given
// priority in case it does.
module hwlock_array
    import hwlock_pkg::*;
#(
    parameter int NUM_LOCKS = 32,
    parameter int IDX_W     = $clog2(NUM_LOCKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic                 clr_en,
    input  logic [IDX_W-1:0]     idx,
    output logic [NUM_LOCKS-1:0] state
);

    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
        logic hit;
        assign hit = (idx == IDX_W'(g));

        // Hold one lock's state: reset frees it, a set takes it, a clear frees it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                state[g] <= LOCK_FREE;
            else if (set_en && hit)
                state[g] <= LOCK_HELD;
            else if (clr_en && hit)
                state[g] <= LOCK_FREE;
        end
    end

endmodule

// File: rtl/hwlock_rdpath.sv
// Module: registered read-data path and ready flag.
// Builds the status word, picks the read value from the decoded target,
// and registers it, so data appears the cycle after the request. When no
// read is requested, rdata is zero on the next cycle.
module hwlock_rdpath
    import hwlock_pkg::*;
#(
    parameter int NUM_LOCKS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  sel_e              sel,
    input  logic              lock_bit,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [COUNT_W-1:0] COUNT_CODE = COUNT_W'(NUM_LOCKS / LOCKS_PER_UNIT);

    logic              ready_q;
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] rd_value;

    // Ready flag: low in reset, high from the first cycle after it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ready_q <= 1'b0;
        else
            ready_q <= 1'b1;
    end

    // Put together the status word: count field plus ready bit.
    always_comb begin
        status_word = '0;
        status_word[COUNT_LSB +: COUNT_W] = COUNT_CODE;
        status_word[0] = ready_q;
    end

    // Select the value the current read returns.
    always_comb begin
        unique case (sel)
            SEL_STATUS: rd_value = status_word;
            SEL_LOCK:   rd_value = {{(DATA_W-1){1'b0}}, lock_bit};
            default:    rd_value = '0;
        endcase
    end

    // Register the read data; idle cycles return zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_value;
        else
            rdata <= '0;
    end

endmodule

// File: rtl/hw_lock_bank.sv
// Module: top of the hardware lock bank.
// A read of a lock register is a test-and-set: it returns the old state
// and leaves the lock held. A write of zero frees the lock. A read wins
// over a write in the same cycle. Assumes one bus access per cycle.
// NUM_LOCKS must be 32, 64, 128 or 256.
module hw_lock_bank
    import hwlock_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_LOCKS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);

    localparam int IDX_W = $clog2(NUM_LOCKS);

    if (!(NUM_LOCKS == 32 || NUM_LOCKS == 64 || NUM_LOCKS == 128 || NUM_LOCKS == 256))
        begin : g_bad_count
            $error("NUM_LOCKS must be 32, 64, 128 or 256");
        end

    sel_e                 sel;
    logic [IDX_W-1:0]     idx;
    logic [NUM_LOCKS-1:0] lock_q;
    logic                 set_en;
    logic                 clr_en;
    logic                 lock_bit;

    hwlock_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_LOCKS(NUM_LOCKS),
        .IDX_W    (IDX_W)
    ) u_decode (
        .addr(addr),
        .sel (sel),
        .idx (idx)
    );

    // Turn the bus access into a set or clear request; a read blocks the write.
    always_comb begin
        set_en = rd_en && (sel == SEL_LOCK);
        clr_en = wr_en && !rd_en && (sel == SEL_LOCK) && (wdata == 32'd0);
    end

    hwlock_array #(
        .NUM_LOCKS(NUM_LOCKS),
        .IDX_W    (IDX_W)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .set_en(set_en),
        .clr_en(clr_en),
        .idx   (idx),
        .state (lock_q)
    );

    // Pick the addressed lock's state before this edge's update.
    always_comb lock_bit = lock_q[idx];

    hwlock_rdpath #(
        .NUM_LOCKS(NUM_LOCKS)
    ) u_rdpath (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .sel     (sel),
        .lock_bit(lock_bit),
        .rdata   (rdata)
    );

endmodule

// File: rtl/hwlock_checker.sv
// Module: property checker for the lock bank, bound to the top module.
// Re-derives the address decode on its own and watches the lock state
// vector against the bus traffic.
module hwlock_checker #(
    parameter int ADDR_W    = 12,
    parameter int NUM_LOCKS = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    addr,
    input logic                 rd_en,
    input logic                 wr_en,
    input logic [31:0]          wdata,
    input logic [31:0]          rdata,
    input logic [NUM_LOCKS-1:0] lock_q
);

    int   a_int;
    logic chk_lock;
    int   chk_idx;
    logic chk_status;

    // Decode the address independently, using plain integer arithmetic.
    always_comb begin
        a_int      = int'(addr);
        chk_status = (a_int == 'h14);
        chk_lock   = (a_int >= 'h800) && (a_int < 'h800 + 4 * NUM_LOCKS) && (a_int % 4 == 0);
        chk_idx    = chk_lock ? (a_int - 'h800) / 4 : 0;
    end

    AST_RESET_FREE: assert property (@(posedge clk) !rst_n |=> (lock_q == '0) && (rdata == 32'd0)); // R1

    AST_STATUS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && chk_status) |=> (rdata == ((32'(NUM_LOCKS / 32) << 24) | 32'd1))); // R2

    AST_FREE_READ_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && chk_lock && !lock_q[chk_idx]) |=> (rdata == 32'd0) && lock_q[$past(chk_idx)]); // R3

    AST_HELD_READ_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && chk_lock && lock_q[chk_idx]) |=> (rdata == 32'd1) && lock_q[$past(chk_idx)]); // R4

    AST_NO_STRAY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !(wr_en && chk_lock && wdata == 32'd0)) |=> $stable(lock_q)); // R6

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !chk_lock && !chk_status) |=> (rdata == 32'd0) && $stable(lock_q)); // R8

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == 32'd0)); // R10

    AST_SINGLE_ACQUIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lock_q & ~$past(lock_q)) <= 1); // R11

endmodule

bind hw_lock_bank hwlock_checker #(
    .ADDR_W   (ADDR_W),
    .NUM_LOCKS(NUM_LOCKS)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .wdata (wdata),
    .rdata (rdata),
    .lock_q(lock_q)
);

// File: tb/hw_lock_bank_test.sv
// Bench: drives bus accesses on the falling edge, keeps a behavioural
// model of the lock bank, and compares rdata with it on every cycle.
module hw_lock_bank_test;

    localparam int ADDR_W    = 12;
    localparam int NUM_LOCKS = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              rd_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    bit  model_lock [NUM_LOCKS];

    always #4 clk = ~clk;   // 125 MHz

    hw_lock_bank #(.ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata)
    );

    function automatic int lock_index(int a);
        if (a >= 'h800 && a < 'h800 + 4 * NUM_LOCKS && (a % 4) == 0)
            return (a - 'h800) / 4;
        return -1;
    endfunction

    task automatic compare(logic [31:0] exp, string tag);
        n_cmp++;
        if (rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: rdata=%h expected=%h at %0t", tag, rdata, exp, $time);
        end
    endtask

    // One bus cycle: drive, update the model, then check rdata after the edge.
    task automatic cycle(bit rd, bit wr, int a, logic [31:0] wd, string tag);
        logic [31:0] exp;
        int li;
        addr  = ADDR_W'(a);
        rd_en = rd;
        wr_en = wr;
        wdata = wd;
        exp   = 32'd0;
        li    = lock_index(a);
        if (rd) begin
            if (a == 'h14)
                exp = (32'(NUM_LOCKS / 32) << 24) | 32'd1;
            else if (li >= 0) begin
                exp = {31'd0, model_lock[li]};
                model_lock[li] = 1'b1;
            end
        end else if (wr && li >= 0 && wd == 32'd0) begin
            model_lock[li] = 1'b0;
        end
        @(negedge clk);
        compare(exp, tag);
    endtask

    task automatic rd_lock(int i, string tag);
        cycle(1'b1, 1'b0, 'h800 + 4 * i, 32'd0, tag);
    endtask

    task automatic wr_lock(int i, logic [31:0] v, string tag);
        cycle(1'b0, 1'b1, 'h800 + 4 * i, v, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NUM_LOCKS; i++) model_lock[i] = 1'b0;
        @(negedge clk);
        // R1: rdata is zero while reset is held
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            compare(32'd0, "R1 in reset");
        end
        rst_n = 1'b1;
        cycle(1'b0, 1'b0, 0, 32'd0, "R10 idle after reset");
        cycle(1'b1, 1'b0, 'h14, 32'd0, "R2 status read");
        // R1 and R3: first sweep finds every lock free and takes it
        for (int i = 0; i < NUM_LOCKS; i++) rd_lock(i, "R3 acquire free");
        // R4: second sweep finds every lock held
        for (int i = 0; i < NUM_LOCKS; i++) rd_lock(i, "R4 read held");
        // R5 / R11: free lock 3 only, then look at its neighbours
        wr_lock(3, 32'd0, "R5 release write");
        rd_lock(2, "R11 neighbour below");
        rd_lock(3, "R5 reacquire after release");
        rd_lock(4, "R11 neighbour above");
        rd_lock(3, "R4 held after reacquire");
        // R6: nonzero writes leave the lock held
        wr_lock(7, 32'd1, "R6 nonzero write");
        wr_lock(7, 32'h8000_0000, "R6 nonzero write");
        rd_lock(7, "R6 still held");
        // R7: a status write has no effect
        cycle(1'b0, 1'b1, 'h14, 32'd0, "R7 status write");
        cycle(1'b1, 1'b0, 'h14, 32'd0, "R7 status unchanged");
        // R8: unmapped, out-of-range and misaligned offsets
        wr_lock(12, 32'd0, "R5 release 12");
        cycle(1'b1, 1'b0, 'h100, 32'd0, "R8 unmapped read");
        cycle(1'b1, 1'b0, 'h800 + 4 * NUM_LOCKS, 32'd0, "R8 beyond count");
        cycle(1'b1, 1'b0, 'h800 + 4 * 12 + 2, 32'd0, "R8 misaligned");
        cycle(1'b0, 1'b1, 'h800 + 4 * 13 + 1, 32'd0, "R8 misaligned write");
        rd_lock(12, "R8 lock 12 untouched");
        rd_lock(13, "R8 lock 13 still held");
        // R9: a read and write collide; the read wins
        cycle(1'b1, 1'b1, 'h800 + 4 * 9, 32'd0, "R9 read wins");
        rd_lock(9, "R9 write dropped");
        wr_lock(20, 32'd0, "R5 release 20");
        cycle(1'b1, 1'b1, 'h800 + 4 * 20, 32'd0, "R9 collide on free");
        rd_lock(20, "R9 lock taken");
        // R11: release all in reverse, reacquire in reverse order
        for (int i = NUM_LOCKS - 1; i >= 0; i--) wr_lock(i, 32'd0, "R10 write cycle");
        for (int i = NUM_LOCKS - 1; i >= 0; i--) rd_lock(i, "R11 reverse acquire");
        cycle(1'b0, 1'b0, 0, 32'd0, "R10 idle");
        // R1: reset again frees everything
        rst_n = 1'b0;
        @(negedge clk);
        compare(32'd0, "R1 reset again");
        rst_n = 1'b1;
        for (int i = 0; i < NUM_LOCKS; i++) model_lock[i] = 1'b0;
        rd_lock(0, "R1 free after reset");
        rd_lock(NUM_LOCKS - 1, "R1 free after reset");
        cycle(1'b0, 1'b0, 0, 32'd0, "R10 idle");
        finish_run();
    end

endmodule